// File: doc/BRIEF.md
# Channel Access Coherence Controller

This block sits between an I/O channel and a two-processor memory system in which each processor owns a store-in cache. A store-in cache keeps modified lines to itself until they are evicted or purged, so main storage may be stale. The block makes sure a channel access always sees, or updates, the current copy of a line.

For each channel request the block asks both cache directories about the addressed line. It then sends the access along one of three paths. If the line is in the local cache, the access goes to the local cache. If the line is missing locally and the other cache either lacks it or holds a clean copy, the access goes to main storage. If the line is missing locally but the other cache holds a modified copy, the block first has that line cast out to storage, marks the remote copy clean, and then performs the access against storage. Only one request is in flight at a time, and the channel is held off until the response is returned.

Top module: `chan_coh_ctrl`

## Requirements
- R1: Each accepted request (`req_valid` and `req_ready` both high at a clock edge) raises `dir_lookup` for exactly that one cycle, with `dir_addr` equal to the request address. The directory answers on `loc_present`, `oth_present` and `oth_modified` are used in the cycle after acceptance.
- R2: When `loc_present` is 1, the access uses only the cache port. No storage access and no castout takes place, and storage contents stay unchanged.
- R3: When `loc_present` is 0 and the other cache is either absent (`oth_present`=0) or clean (`oth_modified`=0), the access uses only the storage port. The local cache contents stay unchanged.
- R4: When `loc_present` is 0, `oth_present` is 1 and `oth_modified` is 1, `co_req` is raised with `co_addr` equal to the request address. `mem_req` stays low until `co_done` has been seen, and the storage access is performed after that.
- R5: In the cycle after a castout completes, `oth_clr_mod` is high for one cycle with `oth_clr_addr` equal to the line address. A later request to that line therefore goes straight to storage.
- R6: `req_ready` is low from the cycle after acceptance until the response has been delivered. Only one request is processed at a time.
- R7: `rsp_valid` is a one-cycle pulse in the cycle after the selected path raises its done signal. For a read, `rsp_rdata` carries the data that path returned.
- R8: The write flag, the address and the write data of the request reach the selected cache or storage port unchanged.
- R9: After reset, `req_ready` is 1, and `cache_req`, `mem_req`, `co_req`, `oth_clr_mod` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Channel request valid |
| req_ready | output | 1 | Controller idle; request is accepted |
| req_write | input | 1 | 1 = channel write, 0 = channel read |
| req_addr | input | ADDR_W | Line address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data of the response |
| dir_lookup | output | 1 | Lookup strobe to both directories |
| dir_addr | output | ADDR_W | Lookup address |
| loc_present | input | 1 | Line present in the local cache |
| oth_present | input | 1 | Line present in the other cache |
| oth_modified | input | 1 | Other cache's copy is modified |
| oth_clr_mod | output | 1 | Mark the other cache's line unmodified |
| oth_clr_addr | output | ADDR_W | Line whose modified state is cleared |
| cache_req | output | 1 | Local cache access request |
| cache_write | output | 1 | Cache access is a write |
| cache_addr | output | ADDR_W | Cache access address |
| cache_wdata | output | DATA_W | Cache write data |
| cache_rdata | input | DATA_W | Cache read data |
| cache_done | input | 1 | Cache access complete |
| mem_req | output | 1 | Storage access request |
| mem_write | output | 1 | Storage access is a write |
| mem_addr | output | ADDR_W | Storage address |
| mem_wdata | output | DATA_W | Storage write data |
| mem_rdata | input | DATA_W | Storage read data |
| mem_done | input | 1 | Storage access complete |
| co_req | output | 1 | Castout request to the other cache |
| co_addr | output | ADDR_W | Castout line address |
| co_done | input | 1 | Castout written to storage |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=32. It models a small line space indexed by the low four address bits, so that the local cache, the other cache, storage and both directories fit in short arrays the bench can fully track. This covers all eight combinations of local presence, remote presence and remote modified state, each as a read and as a write. The storage, cache and castout responders take different numbers of cycles, so a storage access that starts before the castout ends returns stale data. A follow-up read of a line that was cast out confirms that the cleared modified state sends it straight to storage.

// File: rtl/chan_coh_pkg.sv
package chan_coh_pkg;

  typedef enum logic [1:0] {
    RT_CACHE = 2'd0,
    RT_MEM   = 2'd1,
    RT_CAST  = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOOK  = 3'd1,
    S_CACHE = 3'd2,
    S_CAST  = 3'd3,
    S_MEM   = 3'd4,
    S_RESP  = 3'd5
  } seq_e;

  // Three-way target choice from the directory answers.
  function automatic route_e pick_route(input logic loc_hit,
                                        input logic oth_hit,
                                        input logic oth_dirty);
    if (loc_hit)                return RT_CACHE;
    else if (oth_hit && oth_dirty) return RT_CAST;
    else                        return RT_MEM;
  endfunction

endpackage

// File: rtl/chan_coh_hold.sv
module chan_coh_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_write <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
    end else if (take) begin
      out_write <= in_write;
      out_addr  <= in_addr;
      out_wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/chan_coh_seq.sv
module chan_coh_seq
  import chan_coh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic loc_present,
  input  logic oth_present,
  input  logic oth_modified,
  input  logic cache_done,
  input  logic mem_done,
  input  logic co_done,
  output logic busy,
  output logic cache_go,
  output logic mem_go,
  output logic co_go,
  output logic clr_pulse,
  output logic rsp_pulse,
  output logic cache_fire,
  output logic mem_fire
);

  seq_e   state, state_nx;
  route_e route_now;
  logic   co_fire;

  assign route_now = pick_route(loc_present, oth_present, oth_modified);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (accept) state_nx = S_LOOK;
      S_LOOK: begin
        unique case (route_now)
          RT_CACHE: state_nx = S_CACHE;
          RT_CAST:  state_nx = S_CAST;
          default:  state_nx = S_MEM;
        endcase
      end
      S_CACHE: if (cache_done) state_nx = S_RESP;
      S_CAST:  if (co_done)    state_nx = S_MEM;
      S_MEM:   if (mem_done)   state_nx = S_RESP;
      S_RESP:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  assign busy       = (state != S_IDLE);
  assign cache_go   = (state == S_CACHE);
  assign mem_go     = (state == S_MEM);
  assign co_go      = (state == S_CAST);
  assign rsp_pulse  = (state == S_RESP);
  assign cache_fire = cache_go && cache_done;
  assign mem_fire   = mem_go && mem_done;
  assign co_fire    = co_go && co_done;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_pulse <= 1'b0;
    else        clr_pulse <= co_fire;
  end

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r4_hold_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (co_go && !co_done) |=> !mem_go);
  a_r4_then_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (co_go && co_done) |=> mem_go);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (co_go && co_done) |=> clr_pulse);
  a_r5_once: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pulse |=> (!rsp_pulse && !busy));
  a_r7_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_fire || mem_fire) |=> rsp_pulse);

endmodule

// File: rtl/chan_coh_rdata.sv
module chan_coh_rdata #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_fire,
  input  logic [DATA_W-1:0] cache_rdata,
  input  logic              mem_fire,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n)          rsp_rdata <= '0;
    else if (cache_fire) rsp_rdata <= cache_rdata;
    else if (mem_fire)   rsp_rdata <= mem_rdata;
  end

endmodule

// File: rtl/chan_coh_ctrl.sv
module chan_coh_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dir_lookup,
  output logic [ADDR_W-1:0] dir_addr,
  input  logic              loc_present,
  input  logic              oth_present,
  input  logic              oth_modified,
  output logic              oth_clr_mod,
  output logic [ADDR_W-1:0] oth_clr_addr,
  output logic              cache_req,
  output logic              cache_write,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [DATA_W-1:0] cache_wdata,
  input  logic [DATA_W-1:0] cache_rdata,
  input  logic              cache_done,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic              co_req,
  output logic [ADDR_W-1:0] co_addr,
  input  logic              co_done
);

  logic              accept, busy;
  logic              h_write;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              cache_go, mem_go, co_go;
  logic              cache_fire, mem_fire;

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign dir_lookup = accept;
  assign dir_addr   = req_addr;

  chan_coh_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
    .out_write(h_write), .out_addr(h_addr), .out_wdata(h_wdata)
  );

  chan_coh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .loc_present(loc_present), .oth_present(oth_present),
    .oth_modified(oth_modified),
    .cache_done(cache_done), .mem_done(mem_done), .co_done(co_done),
    .busy(busy), .cache_go(cache_go), .mem_go(mem_go), .co_go(co_go),
    .clr_pulse(oth_clr_mod), .rsp_pulse(rsp_valid),
    .cache_fire(cache_fire), .mem_fire(mem_fire)
  );

  chan_coh_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk(clk), .rst_n(rst_n),
    .cache_fire(cache_fire), .cache_rdata(cache_rdata),
    .mem_fire(mem_fire), .mem_rdata(mem_rdata),
    .rsp_rdata(rsp_rdata)
  );

  assign cache_req    = cache_go;
  assign cache_write  = h_write;
  assign cache_addr   = h_addr;
  assign cache_wdata  = h_wdata;
  assign mem_req      = mem_go;
  assign mem_write    = h_write;
  assign mem_addr     = h_addr;
  assign mem_wdata    = h_wdata;
  assign co_req       = co_go;
  assign co_addr      = h_addr;
  assign oth_clr_addr = h_addr;

  a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req |-> (!mem_req && !co_req));
  a_r1_once: assert property (@(posedge clk) disable iff (!rst_n)
    dir_lookup |=> !dir_lookup);
  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req || mem_req || co_req) |-> !req_ready);

endmodule

// File: tb/chan_coh_ctrl_tb.sv
module chan_coh_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, dir_lookup, oth_clr_mod;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] dir_addr, oth_clr_addr, cache_addr, mem_addr, co_addr;
  logic loc_present = 1'b0, oth_present = 1'b0, oth_modified = 1'b0;
  logic cache_req, cache_write, mem_req, mem_write, co_req;
  logic [DW-1:0] cache_wdata, mem_wdata;
  logic [DW-1:0] cache_rdata = '0, mem_rdata = '0;
  logic cache_done = 1'b0, mem_done = 1'b0, co_done = 1'b0;

  always #4 clk = ~clk;

  chan_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  // bench-side model of directories and data
  logic          lp [16], op [16], om [16];
  logic [DW-1:0] c_arr [16], o_arr [16], m_arr [16];

  typedef struct {
    int            rt;   // 0 cache, 1 storage, 2 castout then storage
    logic          wr;
    logic [3:0]    a;
    logic [DW-1:0] d;
    logic [DW-1:0] exp_rd;
    logic [DW-1:0] keep;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  int n_look = 0, n_cache = 0, n_mem = 0, n_co = 0, n_clr = 0;
  bit bad_order = 0, co_fin = 0, bad_clr_addr = 0, rsp_prev = 0;
  int mem_cnt = 0, co_cnt = 0;

  task automatic chk(input bit ok, input string r, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // responders and monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_prev) chk(!rsp_valid, "R7 pulse width", DW'(rsp_valid), 0);
        rsp_prev = rsp_valid;
        if (dir_lookup) begin
          n_look++;
          lp[dir_addr[3:0]] = lp[dir_addr[3:0]];
          loc_present  = lp[dir_addr[3:0]];
          oth_present  = op[dir_addr[3:0]];
          oth_modified = om[dir_addr[3:0]];
        end
        if (oth_clr_mod) begin
          n_clr++;
          if (q.size() != 0 && oth_clr_addr[3:0] != q[0].a) bad_clr_addr = 1;
          om[oth_clr_addr[3:0]] = 1'b0;
        end
        if (mem_req && q.size() != 0 && q[0].rt == 2 && !co_fin) bad_order = 1;
        if (rsp_valid && q.size() != 0) begin
          exp_t e;
          e = q.pop_front();
          chk(n_look == 1, "R1 lookup count", DW'(n_look), 1);
          if (e.rt == 0) begin
            chk(n_cache == 1 && n_mem == 0 && n_co == 0, "R2 cache only",
                DW'(n_cache*16 + n_mem*4 + n_co), 16);
            if (e.wr) begin
              chk(c_arr[e.a] == e.d, "R8 cache write", c_arr[e.a], e.d);
              chk(m_arr[e.a] == e.keep, "R2 storage untouched", m_arr[e.a], e.keep);
            end
          end else if (e.rt == 1) begin
            chk(n_mem == 1 && n_cache == 0 && n_co == 0, "R3 storage only",
                DW'(n_cache*16 + n_mem*4 + n_co), 4);
            if (e.wr) begin
              chk(m_arr[e.a] == e.d, "R8 storage write", m_arr[e.a], e.d);
              chk(c_arr[e.a] == e.keep, "R3 cache untouched", c_arr[e.a], e.keep);
            end
          end else begin
            chk(n_co == 1 && n_mem == 1 && n_cache == 0, "R4 castout then storage",
                DW'(n_cache*16 + n_mem*4 + n_co), 5);
            chk(!bad_order, "R4 storage waits for castout", DW'(bad_order), 0);
            chk(n_clr == 1 && !bad_clr_addr, "R5 clear pulse", DW'(n_clr), 1);
            if (e.wr) chk(m_arr[e.a] == e.d, "R8 write after castout", m_arr[e.a], e.d);
          end
          if (e.rt != 2) chk(n_clr == 0, "R5 no clear", DW'(n_clr), 0);
          if (!e.wr) chk(rsp_rdata == e.exp_rd, "R7 read data", rsp_rdata, e.exp_rd);
          n_look = 0; n_cache = 0; n_mem = 0; n_co = 0; n_clr = 0;
          bad_order = 0; co_fin = 0; bad_clr_addr = 0;
        end
        // cache: one-cycle latency
        if (cache_req && !cache_done) begin
          n_cache++;
          cache_rdata = c_arr[cache_addr[3:0]];
          if (cache_write) c_arr[cache_addr[3:0]] = cache_wdata;
          cache_done = 1'b1;
        end else cache_done = 1'b0;
        // castout: two cycles, copies the remote line into storage
        if (co_req && !co_done) begin
          co_cnt++;
          if (co_cnt == 2) begin
            co_cnt = 0; n_co++; co_fin = 1;
            m_arr[co_addr[3:0]] = o_arr[co_addr[3:0]];
            co_done = 1'b1;
          end
        end else co_done = 1'b0;
        // storage: three cycles
        if (mem_req && !mem_done) begin
          mem_cnt++;
          if (mem_cnt == 3) begin
            mem_cnt = 0; n_mem++;
            mem_rdata = m_arr[mem_addr[3:0]];
            if (mem_write) m_arr[mem_addr[3:0]] = mem_wdata;
            mem_done = 1'b1;
          end
        end else mem_done = 1'b0;
      end
    end
  end

  // driver: computes the expected route and data, then issues the request
  task automatic do_req(input logic wr, input logic [3:0] a, input logic [DW-1:0] d);
    exp_t e;
    e.wr = wr; e.a = a; e.d = d;
    if (lp[a])                e.rt = 0;
    else if (op[a] && om[a])  e.rt = 2;
    else                      e.rt = 1;
    e.exp_rd = (e.rt == 0) ? c_arr[a] : (e.rt == 2) ? o_arr[a] : m_arr[a];
    e.keep   = (e.rt == 0) ? m_arr[a] : c_arr[a];
    q.push_back(e);
    @(posedge clk); #1;
    chk(req_ready, "R6 ready when idle", DW'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(!req_ready, "R6 busy after accept", DW'(req_ready), 0);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      lp[i] = 0; op[i] = 0; om[i] = 0;
      c_arr[i] = 32'hC000_0000 + i;
      o_arr[i] = 32'h0D00_0000 + i;
      m_arr[i] = 32'h3000_0000 + i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cache_req && !mem_req && !co_req && !oth_clr_mod && !rsp_valid,
        "R9 reset state", DW'({req_ready, cache_req, mem_req, co_req, rsp_valid}), 32'h10);
    for (int w = 0; w < 2; w++) begin
      for (int c = 0; c < 8; c++) begin
        logic [3:0] a;
        a = 4'(w * 8 + c);
        lp[a] = c[2]; op[a] = c[1]; om[a] = c[0];
        do_req(w[0], a, 32'hA500_0000 + a * 32'h11);
      end
    end
    // lines 3 and 11 were cast out: their remote copy is now clean (R5)
    do_req(1'b0, 4'd3, '0);
    do_req(1'b0, 4'd11, '0);
    chk(om[3] == 1'b0, "R5 remote marked clean", DW'(om[3]), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule